// File: doc/BRIEF.md
# Vectored Interrupt Controller with Scattered Source Bits

This block gathers up to 64 level-sensitive interrupt sources and presents them to a processor through a small register bus and one interrupt line. Source number `v` (1 to 63) owns exactly one bit in either the high or the low 32-bit word. Which word and which bit it owns comes from a fixed scatter pattern, not from arithmetic on `v`. For each word there is an enable register and a pending register. A read-only vector register names the most urgent enabled pending source.

Software handles an interrupt in four steps. It reads the vector. It disables that source and writes a one to its pending bit. It services the source. It then enables the source again. Pending bits follow their inputs, so a source whose input is still active becomes pending again at once. The processor line is a registered OR of all enabled pending bits.

There is no state machine. All state is held in the enable and pending words plus the registered interrupt line. Every update happens on the single clock edge that follows each bus write and each input sample.

Top module: `icx_ctrl`

## Requirements
- R1: After reset, both enable words, both pending words, the vector register and `irq_o` read zero. Writing 0xFFFFFFFF to both pending words while no input is active clears every pending bit.
- R2: In an enable word, bit 1 lets the matching pending bit drive the vector and `irq_o`, and bit 0 blocks it. A write to an enable word replaces all 32 bits on the next clock edge.
- R3: Writing a 1 to a pending bit clears it on the next edge if its input is inactive. Writing a 0 leaves the bit unchanged.
- R4: While its input is high, a pending bit is set on the next edge and stays set, even across a write-one-to-clear.
- R5: The source-to-bit pattern is fixed, with word index 0 meaning high and 1 meaning low:
  - Sources 1..15 use low bit `16-v`.
  - Sources 32..47 use low bit `63-v`.
  - Sources 48..63 use high bit `v-32`.
  - Source 16 uses high bit 2, source 17 high bit 1, source 31 high bit 0, and sources 18..30 use high bit `33-v`.
- R6: The vector register returns the winning source number in bits 31:26 and zero in bits 25:0. The value 0 means that no enabled source is pending.
- R7: Among enabled pending sources, the smallest source number wins. Input 0 is ignored and never sets a pending bit.
- R8: `irq_o` equals, one clock later, whether any enabled bit is pending in either word.
- R9: Reading any register, the vector included, changes no state.
- R10: The register is selected by byte address bits 4:2: enable-high 0x00, enable-low 0x04, pending-high 0x08, pending-low 0x0C, vector 0x10. Other addresses read zero and ignore writes, and the vector ignores writes. Reads are combinational and return live values.
- R11: An enable write followed on the very next cycle by a pending write both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Level interrupt inputs, bit v is source v |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when 1 together with strobe |
| bus_addr_i | input | 5 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with the package defaults: 64 sources, 32-bit words and a 5-bit address. With these values every source from 1 to 63 can be driven on its own, so each of the four scatter segments is reached in both words. So are the irregular entries at sources 16, 17 and 31, and the ignored input 0. The priority cases put winners in different words: a high-word source beats a lower-priority low-word source, and the win is handed back once the first source is cleared.

// File: rtl/icx_pkg.sv
package icx_pkg;
    localparam int unsigned ICX_SRC   = 64;
    localparam int unsigned ICX_DW    = 32;
    localparam int unsigned ICX_WORDS = 2;
    localparam int unsigned ICX_AW    = 5;
    localparam int unsigned ICX_VW    = $clog2(ICX_SRC);
    localparam int unsigned ICX_BW    = $clog2(ICX_DW);

    typedef struct packed {
        logic                hi;
        logic [ICX_BW-1:0]   bitpos;
    } icx_loc_t;

    typedef enum logic [2:0] {
        REG_EN_HI   = 3'd0,
        REG_EN_LO   = 3'd1,
        REG_PEND_HI = 3'd2,
        REG_PEND_LO = 3'd3,
        REG_VEC     = 3'd4
    } icx_reg_e;

    // Word index 0 is the high word, 1 the low word.
    function automatic icx_loc_t icx_locate(input int unsigned v);
        icx_loc_t l;
        l.hi = 1'b0;
        l.bitpos = '0;
        if (v == 0) begin
            l.hi = 1'b0;
            l.bitpos = '0;
        end else if (v < 16) begin
            l.hi = 1'b0;
            l.bitpos = ICX_BW'(16 - v);
        end else if (v < 32) begin
            l.hi = 1'b1;
            if (v == 16)      l.bitpos = ICX_BW'(2);
            else if (v == 17) l.bitpos = ICX_BW'(1);
            else if (v == 31) l.bitpos = ICX_BW'(0);
            else              l.bitpos = ICX_BW'(33 - v);
        end else if (v < 48) begin
            l.hi = 1'b0;
            l.bitpos = ICX_BW'(63 - v);
        end else begin
            l.hi = 1'b1;
            l.bitpos = ICX_BW'(v - 32);
        end
        return l;
    endfunction
endpackage

// File: rtl/icx_route.sv
module icx_route
    import icx_pkg::*;
(
    input  logic [ICX_SRC-1:0]               src_i,
    input  logic [ICX_WORDS-1:0][ICX_DW-1:0] act_w_i,
    output logic [ICX_WORDS-1:0][ICX_DW-1:0] src_w_o,
    output logic [ICX_SRC-1:0]               act_v_o
);
    // Scatter source inputs into words; gather active bits back by source.
    always_comb begin
        src_w_o = '0;
        act_v_o = '0;
        for (int v = 1; v < ICX_SRC; v++) begin
            icx_loc_t l;
            l = icx_locate(v);
            if (l.hi) begin
                src_w_o[0][l.bitpos] = src_i[v];
                act_v_o[v]           = act_w_i[0][l.bitpos];
            end else begin
                src_w_o[1][l.bitpos] = src_i[v];
                act_v_o[v]           = act_w_i[1][l.bitpos];
            end
        end
    end
endmodule

// File: rtl/icx_regs.sv
module icx_regs
    import icx_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ICX_WORDS-1:0]             wr_en_i,
    input  logic [ICX_WORDS-1:0]             w1c_i,
    input  logic [ICX_DW-1:0]                wdata_i,
    input  logic [ICX_WORDS-1:0][ICX_DW-1:0] src_w_i,
    output logic [ICX_WORDS-1:0][ICX_DW-1:0] en_o,
    output logic [ICX_WORDS-1:0][ICX_DW-1:0] pend_o
);
    logic live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    for (genvar w = 0; w < ICX_WORDS; w++) begin : g_word
        logic [ICX_DW-1:0] en_q;
        logic [ICX_DW-1:0] pend_q;
        logic [ICX_DW-1:0] clr_mask;

        assign clr_mask = w1c_i[w] ? wdata_i : '0;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q   <= '0;
                pend_q <= '0;
            end else begin
                if (wr_en_i[w]) en_q <= wdata_i;
                pend_q <= (pend_q & ~clr_mask) | src_w_i[w];
            end
        end

        assign en_o[w]   = en_q;
        assign pend_o[w] = pend_q;

        assert_en_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en_i[w] |=> (en_o[w] == $past(wdata_i)));

        assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
            w1c_i[w] |=> ((pend_o[w] & $past(wdata_i)) == ($past(src_w_i[w]) & $past(wdata_i))));

        assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            live_q |-> ((pend_o[w] & $past(src_w_i[w])) == $past(src_w_i[w])));
    end
endmodule

// File: rtl/icx_prio.sv
module icx_prio
    import icx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ICX_SRC-1:0]   act_i,
    output logic [ICX_VW-1:0]    vec_o
);
    always_comb begin
        vec_o = '0;
        for (int v = ICX_SRC - 1; v >= 1; v--) begin
            if (act_i[v]) vec_o = ICX_VW'(v);
        end
    end

    assert_vec_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_o == '0) == (act_i[ICX_SRC-1:1] == '0));

    assert_vec_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_o != '0) |-> (act_i[vec_o] &&
            ((act_i & ((ICX_SRC'(1) << vec_o) - ICX_SRC'(1)) & ~ICX_SRC'(1)) == '0)));
endmodule

// File: rtl/icx_ctrl.sv
module icx_ctrl
    import icx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ICX_SRC-1:0]   src_i,
    input  logic                 bus_sel_i,
    input  logic                 bus_we_i,
    input  logic [ICX_AW-1:0]    bus_addr_i,
    input  logic [ICX_DW-1:0]    bus_wdata_i,
    output logic [ICX_DW-1:0]    bus_rdata_o,
    output logic                 irq_o
);
    logic [2:0]                       word_sel;
    logic                             wr_req;
    logic [ICX_WORDS-1:0]             wr_en;
    logic [ICX_WORDS-1:0]             w1c;
    logic [ICX_WORDS-1:0][ICX_DW-1:0] src_w;
    logic [ICX_WORDS-1:0][ICX_DW-1:0] en_w;
    logic [ICX_WORDS-1:0][ICX_DW-1:0] pend_w;
    logic [ICX_WORDS-1:0][ICX_DW-1:0] act_w;
    logic [ICX_SRC-1:0]               act_v;
    logic [ICX_VW-1:0]                vec;
    logic                             any_act;
    logic                             irq_q;

    assign word_sel = bus_addr_i[4:2];
    assign wr_req   = bus_sel_i & bus_we_i;

    always_comb begin
        wr_en = '0;
        w1c   = '0;
        unique case (word_sel)
            REG_EN_HI:   wr_en[0] = wr_req;
            REG_EN_LO:   wr_en[1] = wr_req;
            REG_PEND_HI: w1c[0]   = wr_req;
            REG_PEND_LO: w1c[1]   = wr_req;
            default: ;
        endcase
    end

    icx_route u_route (
        .src_i   (src_i),
        .act_w_i (act_w),
        .src_w_o (src_w),
        .act_v_o (act_v)
    );

    icx_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en),
        .w1c_i   (w1c),
        .wdata_i (bus_wdata_i),
        .src_w_i (src_w),
        .en_o    (en_w),
        .pend_o  (pend_w)
    );

    for (genvar w = 0; w < ICX_WORDS; w++) begin : g_act
        assign act_w[w] = pend_w[w] & en_w[w];
    end

    icx_prio u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .act_i (act_v),
        .vec_o (vec)
    );

    assign any_act = |act_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= any_act;
    end
    assign irq_o = irq_q;

    always_comb begin
        bus_rdata_o = '0;
        unique case (word_sel)
            REG_EN_HI:   bus_rdata_o = en_w[0];
            REG_EN_LO:   bus_rdata_o = en_w[1];
            REG_PEND_HI: bus_rdata_o = pend_w[0];
            REG_PEND_LO: bus_rdata_o = pend_w[1];
            REG_VEC:     bus_rdata_o = {vec, {(ICX_DW-ICX_VW){1'b0}}};
            default: ;
        endcase
    end

    assert_irq_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|(pend_w & en_w)));
endmodule

// File: tb/icx_ctrl_bench.sv
module icx_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        sel = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  addr = 5'h10;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    icx_ctrl u_icx_ctrl (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel_i(sel), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    // Reference model: word 0 high, word 1 low.
    int      t_word [64];
    int      t_bit  [64];
    bit [31:0] m_en   [2];
    bit [31:0] m_pend [2];
    bit        m_irq;

    initial begin
        for (int v = 0; v < 64; v++) begin
            if (v == 0)       begin t_word[v] = -1; t_bit[v] = 0; end
            else if (v <= 15) begin t_word[v] = 1; t_bit[v] = 16 - v; end
            else if (v == 16) begin t_word[v] = 0; t_bit[v] = 2; end
            else if (v == 17) begin t_word[v] = 0; t_bit[v] = 1; end
            else if (v == 31) begin t_word[v] = 0; t_bit[v] = 0; end
            else if (v <= 30) begin t_word[v] = 0; t_bit[v] = 33 - v; end
            else if (v <= 47) begin t_word[v] = 1; t_bit[v] = 63 - v; end
            else              begin t_word[v] = 0; t_bit[v] = v - 32; end
        end
    end

    function automatic int m_vec();
        for (int v = 1; v < 64; v++)
            if (m_pend[t_word[v]][t_bit[v]] && m_en[t_word[v]][t_bit[v]]) return v;
        return 0;
    endfunction

    function automatic logic [31:0] m_read(input logic [4:0] a);
        case (a[4:2])
            3'd0: return m_en[0];
            3'd1: return m_en[1];
            3'd2: return m_pend[0];
            3'd3: return m_pend[1];
            3'd4: return {6'(m_vec()), 26'd0};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en[0] = 0; m_en[1] = 0; m_pend[0] = 0; m_pend[1] = 0; m_irq = 0;
        end else begin
            bit [31:0] s [2];
            m_irq = ((m_pend[0] & m_en[0]) != 0) || ((m_pend[1] & m_en[1]) != 0);
            s[0] = 0; s[1] = 0;
            for (int v = 1; v < 64; v++) if (src[v]) s[t_word[v]][t_bit[v]] = 1'b1;
            if (sel && we) begin
                case (addr[4:2])
                    3'd0: m_en[0] = wdata;
                    3'd1: m_en[1] = wdata;
                    3'd2: m_pend[0] = m_pend[0] & ~wdata;
                    3'd3: m_pend[1] = m_pend[1] & ~wdata;
                    default: ;
                endcase
            end
            m_pend[0] = m_pend[0] | s[0];
            m_pend[1] = m_pend[1] | s[1];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, a quarter period after each edge.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && !done) begin
            chk("R8 irq vs model", {31'd0, irq}, {31'd0, m_irq});
            chk("R10 rdata vs model", rdata, m_read(addr));
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1; we = 1; addr = a; wdata = d;
        @(negedge clk);
        sel = 0; we = 0; addr = 5'h10;
    endtask

    task automatic rdchk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        settle(3);
        rst_n = 1;
        settle(1);
        // R1 reset state
        rdchk("R1 en hi", 5'h00, 0);
        rdchk("R1 en lo", 5'h04, 0);
        rdchk("R1 pend hi", 5'h08, 0);
        rdchk("R1 pend lo", 5'h0C, 0);
        rdchk("R1 vector", 5'h10, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R5/R2: source 5 lands on low bit 11, blocked while disabled
        @(negedge clk); src[5] = 1;
        rdchk("R5 src5 low bit11", 5'h0C, 32'h0000_0800);
        settle(1);
        rdchk("R2 vector blocked", 5'h10, 0);
        chk("R2 irq blocked", {31'd0, irq}, 0);

        // R2/R6/R8: enable it
        wr(5'h04, 32'h0000_0800);
        rdchk("R6 vector 5", 5'h10, 32'h1400_0000);
        settle(1);
        chk("R8 irq raised", {31'd0, irq}, 1);

        // R9: reads leave state alone
        rdchk("R9 vector reread", 5'h10, 32'h1400_0000);
        rdchk("R9 pend after reads", 5'h0C, 32'h0000_0800);

        // R4: clear while input high
        wr(5'h0C, 32'h0000_0800);
        rdchk("R4 pend held", 5'h0C, 32'h0000_0800);

        // R3: writing zero does nothing, writing one clears
        @(negedge clk); src[5] = 0;
        wr(5'h0C, 32'h0);
        rdchk("R3 zero write", 5'h0C, 32'h0000_0800);
        wr(5'h0C, 32'h0000_0800);
        rdchk("R3 one clears", 5'h0C, 0);
        settle(1);
        chk("R3 irq dropped", {31'd0, irq}, 0);

        // R11: acknowledge with back-to-back writes; source 20 is high bit 13
        @(negedge clk); src[20] = 1;
        wr(5'h00, 32'h0000_2000);
        @(negedge clk); src[20] = 0;
        rdchk("R5 src20 high bit13", 5'h08, 32'h0000_2000);
        @(negedge clk);
        sel = 1; we = 1; addr = 5'h00; wdata = 0;
        @(negedge clk);
        addr = 5'h08; wdata = 32'h0000_2000;
        @(negedge clk);
        sel = 0; we = 0; addr = 5'h10;
        rdchk("R11 en hi cleared", 5'h00, 0);
        rdchk("R11 pend hi cleared", 5'h08, 0);
        settle(1);
        chk("R11 irq low", {31'd0, irq}, 0);

        // R7: priority across words, input 0 ignored
        wr(5'h00, 32'hFFFF_FFFF);
        wr(5'h04, 32'hFFFF_FFFF);
        @(negedge clk); src[40] = 1; src[17] = 1; src[0] = 1;
        settle(1);
        rdchk("R7 lowest wins", 5'h10, 32'h4400_0000);
        rdchk("R7 input0 ignored", 5'h0C, 32'h0080_0000);
        rdchk("R5 src17 high bit1", 5'h08, 32'h0000_0002);
        @(negedge clk); src[17] = 0; src[0] = 0;
        wr(5'h08, 32'h0000_0002);
        rdchk("R7 next winner", 5'h10, 32'hA000_0000);
        @(negedge clk); src[40] = 0;
        wr(5'h08, 32'hFFFF_FFFF);
        wr(5'h0C, 32'hFFFF_FFFF);
        rdchk("R1 all clear hi", 5'h08, 0);
        rdchk("R1 all clear lo", 5'h0C, 0);

        // R10: unmapped and vector addresses ignore writes
        wr(5'h14, 32'hDEAD_BEEF);
        wr(5'h10, 32'hFFFF_FFFF);
        rdchk("R10 unmapped reads zero", 5'h14, 0);
        rdchk("R10 vector unchanged", 5'h10, 0);
        rdchk("R10 en hi intact", 5'h00, 32'hFFFF_FFFF);

        // R5 sweep of every source
        for (int v = 1; v < 64; v++) begin
            logic [31:0] eh, el;
            eh = 0; el = 0;
            if (t_word[v] == 0) eh[t_bit[v]] = 1'b1; else el[t_bit[v]] = 1'b1;
            @(negedge clk); src = 64'd1 << v;
            rdchk("R5 sweep hi", 5'h08, eh);
            rdchk("R5 sweep lo", 5'h0C, el);
            rdchk("R6 sweep vector", 5'h10, {6'(v), 26'd0});
            @(negedge clk); src = 0;
            wr(5'h08, 32'hFFFF_FFFF);
            wr(5'h0C, 32'hFFFF_FFFF);
        end

        settle(2);
        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule